// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Control Sequencer

This block is a host-side controller for a register-based sigma-delta converter. The converter is attached over a four-wire serial link in clock-idle-high mode. Its single data-out line does two jobs: it carries read data, and it signals that a conversion has finished. After a start pulse the sequencer brings the converter up on its own:

- It clocks out a long run of ones to reset the serial port.
- It waits out a settling interval.
- It reads the identity byte and checks it.
- It writes the operating and configuration words.
- It walks through an eight-step calibration list, four inputs with a zero and a full step each.

Once bring-up is done, user logic issues single-conversion requests through a valid/ready port. Each request names a channel and an output-rate divider. For each request the sequencer does the following:

- It writes the channel into the configuration word, leaving the other configuration bits unchanged.
- It writes the operating word, which starts one conversion.
- It keeps chip select low and watches the data-out line for a falling edge.
- It reads back the 24-bit result and returns it as a one-cycle response with an error code.

Top module: `sdadc_seq`

## Requirements
- R1: While reset is asserted and directly after it, chip select and the serial clock are high, and busy, request-ready and response-valid are low.
- R2: A start pulse produces exactly 48 serial clocks with the data-in line high and chip select low. No further serial clock edge follows for at least RESET_WAIT clocks.
- R3: The controller then reads the identity register (address 4, 8 bits). The warning output goes high exactly when bits 3:0 of the returned byte differ from EXP_ID. Bring-up continues in both cases.
- R4: Every access starts with a command byte. In that byte bit 7 is 0, bit 6 is 1 for a read, bits 5:3 hold the address and bits 2:0 are 0. Words at addresses 1, 2, 3, 6 and 7 are 24 bits; the other addresses are 8 bits.
- R5: The first write to the operating register (address 1) carries: mode code 2 (idle) in bits 23:21, 0 in bit 20, CLK_SRC in bits 19:18, 0 in bits 17:10 and 480 in bits 9:0. The first write to the configuration register (address 2) is CONF_BASE with its channel field, bits 18:8, cleared.
- R6: Calibration performs eight operating-register writes. Step k (0..7) uses mode code 4 for even k and 5 for odd k. It is preceded by a configuration write whose channel field has only bit 4+k/2 set. No step starts before the previous one has signalled ready.
- R7: For an accepted request with channel c (0..7) and rate r in 1..1023, the controller does three things in order. It writes CONF_BASE with bits 18:8 replaced by a single set bit at position c. It writes mode code 1 with rate r. After the ready edge it reads address 3 (24 bits). The response carries that word with error code 0.
- R8: A request rate of 0 or above 1023 is answered with error code 1 and data 0 on the cycle after acceptance, with no serial clock activity.
- R9: If no falling edge is seen on the data-out line within TIMEOUT clocks of arming the wait, the response carries error code 2.
- R10: Chip select stays low from the first frame of a request until its response, and rises once per served request.
- R11: Request-ready is high only while idle after bring-up. Busy is high from the start pulse until bring-up ends and while a request is open. Response-valid lasts exactly one cycle.
- R12: The data-in line to the converter changes only in a cycle where the serial clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin bring-up sequence |
| busy_o | output | 1 | Bring-up or request in progress |
| id_warn_o | output | 1 | Identity nibble mismatch |
| req_valid_i | input | 1 | Conversion request valid |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_chan_i | input | 3 | Channel index |
| req_rate_i | input | 12 | Output-rate divider |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_data_o | output | 24 | Conversion result |
| rsp_err_o | output | 2 | 0 ok, 1 bad rate, 2 timeout |
| sclk_o | output | 1 | Serial clock, idles high |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Data to converter |
| miso_i | input | 1 | Data/ready from converter |

## Verification
The hardest case to reach is a conversion wait that never ends. A working converter always pulls its data line low, so the bench model of the converter has a switch that keeps its ready indication high through one request. After the timeout response the switch is released, and the bench lets the stuck conversion finish before the next request, so that later requests show the state machine has recovered. The bit-accurate converter model also records every operating and configuration write. This lets the calibration order and the untouched configuration bits be checked from the serial lines alone.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

    localparam logic [2:0] ADR_MODE = 3'd1;
    localparam logic [2:0] ADR_CONF = 3'd2;
    localparam logic [2:0] ADR_DATA = 3'd3;
    localparam logic [2:0] ADR_ID   = 3'd4;

    localparam logic [2:0] OP_SINGLE = 3'd1;
    localparam logic [2:0] OP_IDLE   = 3'd2;
    localparam logic [2:0] OP_CAL_Z  = 3'd4;
    localparam logic [2:0] OP_CAL_F  = 3'd5;

    localparam int          CH_LSB   = 8;
    localparam int          CH_W     = 11;
    localparam logic [9:0]  RATE_DEF = 10'd480;

    typedef enum logic [3:0] {
        ST_OFF, ST_RST, ST_RWAIT, ST_ID, ST_MODE0, ST_CONF0,
        ST_CCONF, ST_CMODE, ST_CWAIT, ST_READY,
        ST_RCONF, ST_RMODE, ST_RWAITC, ST_RREAD, ST_RESP
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_RATE = 2'd1,
        ERR_TMO  = 2'd2
    } rsp_err_t;

    typedef struct packed {
        logic [31:0] word;
        logic [5:0]  nbits;
    } frame_t;

    function automatic logic [7:0] cmd_byte(input logic rd, input logic [2:0] adr);
        return {1'b0, rd, adr, 3'b000};
    endfunction

    function automatic logic [23:0] mode_word(input logic [2:0] op,
                                              input logic [1:0] csrc,
                                              input logic [9:0] rate);
        return {op, 1'b0, csrc, 8'h00, rate};
    endfunction

    function automatic logic [23:0] conf_with_chan(input logic [23:0] base,
                                                   input logic [CH_W-1:0] chans);
        logic [23:0] r;
        r = base;
        r[CH_LSB +: CH_W] = chans;
        return r;
    endfunction

endpackage

// File: rtl/sdadc_shifter.sv
module sdadc_shifter
    import sdadc_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  frame_t      frame_i,
    input  logic        miso_i,
    output logic        sclk_o,
    output logic        mosi_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [31:0] rx_o
);
    localparam int DIV_W = $clog2(DIV + 1);

    logic [DIV_W-1:0] div_q;
    logic [31:0]      sh_q;
    logic [5:0]       len_q, bit_q;
    logic             tick;

    assign tick = busy_o && (div_q == DIV_W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            sh_q   <= '1;
            len_q  <= '0;
            bit_q  <= '0;
            sclk_o <= 1'b1;
            mosi_o <= 1'b1;
            busy_o <= 1'b0;
            done_o <= 1'b0;
            rx_o   <= '0;
        end else begin
            done_o <= 1'b0;
            if (go && !busy_o) begin
                busy_o <= 1'b1;
                sh_q   <= frame_i.word;
                len_q  <= frame_i.nbits;
                bit_q  <= '0;
                div_q  <= '0;
                sclk_o <= 1'b1;
            end else if (busy_o) begin
                div_q <= tick ? '0 : div_q + 1'b1;
                if (tick) begin
                    if (sclk_o) begin
                        sclk_o <= 1'b0;
                        mosi_o <= sh_q[31];
                        sh_q   <= {sh_q[30:0], 1'b1};
                    end else begin
                        sclk_o <= 1'b1;
                        rx_o   <= {rx_o[30:0], miso_i};
                        if (bit_q == len_q - 6'd1) begin
                            busy_o <= 1'b0;
                            done_o <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 6'd1;
                        end
                    end
                end
            end
        end
    end

    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(mosi_o) |-> $fell(sclk_o)); // R12

endmodule

// File: rtl/sdadc_rdy_wait.sv
module sdadc_rdy_wait #(
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic miso_s,
    output logic hit_o,
    output logic tmo_o
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wait_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            wait_q <= 1'b0;
            prev_q <= 1'b1;
            hit_o  <= 1'b0;
            tmo_o  <= 1'b0;
        end else begin
            hit_o  <= 1'b0;
            tmo_o  <= 1'b0;
            prev_q <= miso_s;
            if (arm) begin
                wait_q <= 1'b1;
                cnt_q  <= '0;
            end else if (wait_q) begin
                if (prev_q && !miso_s) begin
                    hit_o  <= 1'b1;
                    wait_q <= 1'b0;
                end else if (cnt_q == CNT_W'(TIMEOUT - 1)) begin
                    tmo_o  <= 1'b1;
                    wait_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_TMO_ONLY_WAITING: assert property (@(posedge clk) disable iff (rst)
        tmo_o |-> $past(wait_q) && !hit_o); // R9

endmodule

// File: rtl/sdadc_seq.sv
module sdadc_seq
    import sdadc_pkg::*;
#(
    parameter int          CLK_DIV    = 4,
    parameter int          RESET_WAIT = 25000,
    parameter int          TIMEOUT    = 1000000,
    parameter logic [3:0]  EXP_ID     = 4'h0,
    parameter logic [1:0]  CLK_SRC    = 2'd2,
    parameter logic [23:0] CONF_BASE  = 24'h000008
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    output logic        busy_o,
    output logic        id_warn_o,
    input  logic        req_valid_i,
    output logic        req_ready_o,
    input  logic [2:0]  req_chan_i,
    input  logic [11:0] req_rate_i,
    output logic        rsp_valid_o,
    output logic [23:0] rsp_data_o,
    output logic [1:0]  rsp_err_o,
    output logic        sclk_o,
    output logic        cs_n_o,
    output logic        mosi_o,
    input  logic        miso_i
);
    localparam int WAIT_W = $clog2(RESET_WAIT + 1);

    seq_state_t        state_q;
    frame_t            fr;
    logic              is_frame, issued_q, fr_go, fr_busy, fr_done;
    logic [31:0]       fr_rx;
    logic              arm_q, hit, tmo;
    logic [1:0]        miso_sync;
    logic [WAIT_W-1:0] wcnt_q;
    logic [2:0]        cal_q, chan_q;
    logic [9:0]        rate_q;
    logic              rate_ok;
    rsp_err_t          err_q;

    assign rate_ok     = (req_rate_i[11:10] == 2'b00) && (req_rate_i[9:0] != 10'd0);
    assign req_ready_o = (state_q == ST_READY);
    assign busy_o      = (state_q != ST_OFF) && (state_q != ST_READY);
    assign cs_n_o      = (state_q == ST_OFF) || (state_q == ST_READY) || (state_q == ST_RESP);
    assign rsp_valid_o = (state_q == ST_RESP);
    assign rsp_err_o   = err_q;

    always_comb begin
        is_frame = 1'b1;
        fr.nbits = 6'd32;
        fr.word  = 32'h0;
        case (state_q)
            ST_RST:   fr = '{word: 32'hFFFF_FFFF, nbits: 6'd48};
            ST_ID:    fr = '{word: {cmd_byte(1'b1, ADR_ID), 24'h0}, nbits: 6'd16};
            ST_MODE0: fr.word = {cmd_byte(1'b0, ADR_MODE), mode_word(OP_IDLE, CLK_SRC, RATE_DEF)};
            ST_CONF0: fr.word = {cmd_byte(1'b0, ADR_CONF), conf_with_chan(CONF_BASE, '0)};
            ST_CCONF: fr.word = {cmd_byte(1'b0, ADR_CONF),
                                 conf_with_chan(CONF_BASE, CH_W'(1) << (3'd4 + {1'b0, cal_q[2:1]}))};
            ST_CMODE: fr.word = {cmd_byte(1'b0, ADR_MODE),
                                 mode_word(cal_q[0] ? OP_CAL_F : OP_CAL_Z, CLK_SRC, rate_q)};
            ST_RCONF: fr.word = {cmd_byte(1'b0, ADR_CONF), conf_with_chan(CONF_BASE, CH_W'(1) << chan_q)};
            ST_RMODE: fr.word = {cmd_byte(1'b0, ADR_MODE), mode_word(OP_SINGLE, CLK_SRC, rate_q)};
            ST_RREAD: fr.word = {cmd_byte(1'b1, ADR_DATA), 24'h0};
            default:  is_frame = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) miso_sync <= 2'b11;
        else     miso_sync <= {miso_sync[0], miso_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_OFF;
            issued_q  <= 1'b0;
            fr_go     <= 1'b0;
            arm_q     <= 1'b0;
            wcnt_q    <= '0;
            cal_q     <= '0;
            chan_q    <= '0;
            rate_q    <= RATE_DEF;
            rsp_data_o <= '0;
            err_q     <= ERR_NONE;
            id_warn_o <= 1'b0;
        end else begin
            fr_go <= 1'b0;
            arm_q <= 1'b0;
            if (is_frame) begin
                if (!issued_q) begin
                    fr_go    <= 1'b1;
                    issued_q <= 1'b1;
                end else if (fr_done) begin
                    issued_q <= 1'b0;
                    case (state_q)
                        ST_RST:   begin state_q <= ST_RWAIT; wcnt_q <= '0; end
                        ST_ID:    begin
                            id_warn_o <= (fr_rx[3:0] != EXP_ID);
                            state_q   <= ST_MODE0;
                        end
                        ST_MODE0: state_q <= ST_CONF0;
                        ST_CONF0: begin state_q <= ST_CCONF; cal_q <= '0; end
                        ST_CCONF: state_q <= ST_CMODE;
                        ST_CMODE: begin state_q <= ST_CWAIT; arm_q <= 1'b1; end
                        ST_RCONF: state_q <= ST_RMODE;
                        ST_RMODE: begin state_q <= ST_RWAITC; arm_q <= 1'b1; end
                        default: begin
                            rsp_data_o <= fr_rx[23:0];
                            err_q      <= ERR_NONE;
                            state_q    <= ST_RESP;
                        end
                    endcase
                end
            end else begin
                case (state_q)
                    ST_OFF:   if (start_i) state_q <= ST_RST;
                    ST_RWAIT: begin
                        if (wcnt_q == WAIT_W'(RESET_WAIT - 1)) state_q <= ST_ID;
                        else wcnt_q <= wcnt_q + 1'b1;
                    end
                    ST_CWAIT: if (hit || tmo) begin
                        if (cal_q == 3'd7) state_q <= ST_READY;
                        else begin
                            cal_q   <= cal_q + 3'd1;
                            state_q <= ST_CCONF;
                        end
                    end
                    ST_READY: if (req_valid_i) begin
                        chan_q <= req_chan_i;
                        if (rate_ok) begin
                            rate_q  <= req_rate_i[9:0];
                            state_q <= ST_RCONF;
                        end else begin
                            rsp_data_o <= '0;
                            err_q      <= ERR_RATE;
                            state_q    <= ST_RESP;
                        end
                    end
                    ST_RWAITC: begin
                        if (hit) state_q <= ST_RREAD;
                        else if (tmo) begin
                            rsp_data_o <= '0;
                            err_q      <= ERR_TMO;
                            state_q    <= ST_RESP;
                        end
                    end
                    default: state_q <= ST_READY;
                endcase
            end
        end
    end

    sdadc_shifter #(.DIV(CLK_DIV)) i_shift (
        .clk(clk), .rst(rst), .go(fr_go), .frame_i(fr), .miso_i(miso_sync[1]),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .busy_o(fr_busy), .done_o(fr_done), .rx_o(fr_rx)
    );

    sdadc_rdy_wait #(.TIMEOUT(TIMEOUT)) i_wait (
        .clk(clk), .rst(rst), .arm(arm_q), .miso_s(miso_sync[1]), .hit_o(hit), .tmo_o(tmo)
    );

    AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        !sclk_o |-> !cs_n_o); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |=> !rsp_valid_o); // R11
    AST_OK_RATE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && rsp_err_o == ERR_NONE) |-> (rate_q != 10'd0)); // R8
    AST_RATE_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && rsp_err_o == ERR_RATE) |-> $past(state_q == ST_READY)); // R8
    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        fr_go |-> !fr_busy); // R4

endmodule

// File: tb/test_sdadc_seq.sv
module test_sdadc_seq;
    localparam int          CLK_DIV    = 4;
    localparam int          RESET_WAIT = 200;
    localparam int          TIMEOUT    = 3000;
    localparam logic [3:0]  EXP_ID     = 4'h4;
    localparam logic [1:0]  CLK_SRC    = 2'd2;
    localparam logic [23:0] CONF_BASE  = 24'h800F13;
    localparam int          CONV_CLKS  = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, id_warn, req_valid = 1'b0, req_ready, rsp_valid;
    logic [2:0]  req_chan = '0;
    logic [11:0] req_rate = '0;
    logic [23:0] rsp_data;
    logic [1:0]  rsp_err;
    logic sclk, cs_n, mosi, miso;

    always #10 clk = ~clk;

    sdadc_seq #(.CLK_DIV(CLK_DIV), .RESET_WAIT(RESET_WAIT), .TIMEOUT(TIMEOUT),
                .EXP_ID(EXP_ID), .CLK_SRC(CLK_SRC), .CONF_BASE(CONF_BASE)) i_sdadc_seq (
        .clk(clk), .rst(rst), .start_i(start), .busy_o(busy), .id_warn_o(id_warn),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_chan_i(req_chan),
        .req_rate_i(req_rate), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
        .rsp_err_o(rsp_err), .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso)
    );

    // ---------------- converter model ----------------
    int          cyc = 0;
    int          ph = 0, bcnt = 0, wid = 8, ones_run = 0, ones_max = 0;
    int          last_one = 0, gap = -1, viol = 0, n_mode = 0, n_conf = 0;
    int          conv_req = 0, conv_seen = 0, conv_cnt = 0;
    int          sclk_falls = 0, cs_rises = 0;
    logic [7:0]  cmd_sr = '0, model_id = 8'hB4;
    logic [2:0]  adr = '0;
    logic [23:0] sr = '0, rd_sr = '0, mode_r = '0, conf_r = '0, conf_first = '0;
    logic [23:0] mode_log [0:255];
    logic [10:0] ch_log [0:255];
    logic        rdy_n = 1'b1, busy_c = 1'b0, no_ready = 1'b0, out_en = 1'b0, out_bit = 1'b0;

    assign miso = out_en ? out_bit : rdy_n;

    function automatic logic [23:0] dfn(input logic [23:0] c, input logic [23:0] m);
        return c ^ {m[9:0], 14'h0} ^ {m[23:21], 21'h0};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (conv_req != conv_seen) begin
            conv_seen <= conv_req;
            rdy_n     <= 1'b1;
            busy_c    <= 1'b1;
            conv_cnt  <= CONV_CLKS;
        end else if (busy_c && !no_ready) begin
            if (conv_cnt == 0) begin
                rdy_n  <= 1'b0;
                busy_c <= 1'b0;
            end else conv_cnt <= conv_cnt - 1;
        end
    end

    always @(posedge cs_n) cs_rises++;

    always @(negedge sclk) begin
        sclk_falls++;
        if (ph == 2 && cmd_sr[6] && bcnt < wid) begin
            out_bit = rd_sr[wid-1-bcnt];
            out_en  = 1'b1;
        end else out_en = 1'b0;
    end

    always @(posedge sclk) if (!cs_n) begin
        if (mosi) ones_run++; else ones_run = 0;
        if (ones_run > ones_max) ones_max = ones_run;
        case (ph)
            0: begin
                cmd_sr = {cmd_sr[6:0], mosi};
                bcnt++;
                if (bcnt == 8) begin
                    if (cmd_sr == 8'hFF) ph = 1;
                    else begin
                        if (cmd_sr[7] || cmd_sr[2:0] != 3'b000) viol++;
                        adr   = cmd_sr[5:3];
                        wid   = (adr == 0 || adr == 4 || adr == 5) ? 8 : 24;
                        rd_sr = (adr == 3'd4) ? {16'h0, model_id} :
                                (adr == 3'd3) ? dfn(conf_r, mode_r) : 24'h0;
                        ph = 2;
                        bcnt = 0;
                    end
                end
            end
            1: begin
                if (!mosi) begin
                    if (gap < 0) gap = cyc - last_one;
                    cmd_sr = 8'h00;
                    bcnt = 1;
                    ph = 0;
                end else last_one = cyc;
            end
            default: begin
                sr = {sr[22:0], mosi};
                bcnt++;
                if (bcnt == wid) begin
                    if (!cmd_sr[6] && adr == 3'd1) begin
                        mode_r = sr;
                        if (n_mode < 256) begin
                            mode_log[n_mode] = sr;
                            ch_log[n_mode]   = conf_r[18:8];
                        end
                        n_mode++;
                        if (sr[23:21] == 3'd1 || sr[23:21] == 3'd4 || sr[23:21] == 3'd5) begin
                            if (busy_c) viol++;
                            conv_req++;
                        end
                    end
                    if (!cmd_sr[6] && adr == 3'd2) begin
                        if (n_conf == 0) conf_first = sr;
                        n_conf++;
                        conf_r = sr;
                    end
                    ph = 0;
                    bcnt = 0;
                    cmd_sr = 8'h00;
                end
            end
        endcase
    end

    // ---------------- checks ----------------
    int nchk = 0, nfail = 0;
    bit wd = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 20000 && !req_ready; i++) @(negedge clk);
    endtask

    task automatic do_req(input logic [2:0] ch, input logic [11:0] rate,
                          output logic [23:0] d, output logic [1:0] e, output int lat);
        int t0;
        wait_ready();
        req_chan  = ch;
        req_rate  = rate;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t0 = cyc;
        d = 'x;
        e = 'x;
        for (int i = 0; i < 20000; i++) begin
            if (rsp_valid) begin
                d = rsp_data;
                e = rsp_err;
                break;
            end
            @(negedge clk);
        end
        lat = cyc - t0;
        @(negedge clk);
        chk(!rsp_valid, "R11 response one cycle", rsp_valid, 0);
    endtask

    task automatic init_run();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n && sclk && !busy && !req_ready && !rsp_valid, "R1 reset state",
            {cs_n, sclk, busy, req_ready, rsp_valid}, 5'b11000);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && sclk && !busy, "R1 after reset", {cs_n, sclk, busy}, 3'b110);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(busy && !req_ready, "R11 busy during bring-up", {busy, req_ready}, 2'b10);
        wait_ready();
    endtask

    initial begin
        fork
            begin : main
                logic [23:0] d, exp_conf, exp_mode;
                logic [1:0]  e;
                int          lat, fb, cr;
                init_run();
                chk(ones_max == 48, "R2 reset ones", ones_max, 48);
                chk(gap >= RESET_WAIT, "R2 settle gap", gap, RESET_WAIT);
                chk(!id_warn, "R3 id match", id_warn, 0);
                chk(req_ready && !busy, "R3 R11 ready after bring-up", {req_ready, busy}, 2'b10);
                chk(mode_log[0] == {3'd2, 1'b0, CLK_SRC, 8'h00, 10'd480}, "R5 init mode word",
                    mode_log[0], {3'd2, 1'b0, CLK_SRC, 8'h00, 10'd480});
                chk(conf_first == (CONF_BASE & ~24'h07FF00), "R5 init conf word",
                    conf_first, CONF_BASE & ~24'h07FF00);
                chk(n_mode == 9, "R6 calibration step count", n_mode, 9);
                for (int k = 0; k < 8; k++) begin
                    chk(mode_log[k+1][23:21] == 3'(4 + (k % 2)), "R6 calibration mode code",
                        mode_log[k+1][23:21], 4 + (k % 2));
                    chk(ch_log[k+1] == 11'(1 << (4 + k / 2)), "R6 calibration channel",
                        ch_log[k+1], 1 << (4 + k / 2));
                end
                // sweep channels and rates
                for (int c = 0; c < 8; c++) begin
                    for (int ri = 0; ri < 3; ri++) begin
                        logic [11:0] r;
                        r = (ri == 0) ? 12'd1 : (ri == 1) ? 12'd480 : 12'd1023;
                        cr = cs_rises;
                        do_req(3'(c), r, d, e, lat);
                        exp_conf = (CONF_BASE & ~24'h07FF00) | (24'h1 << (8 + c));
                        exp_mode = {3'd1, 1'b0, CLK_SRC, 8'h00, r[9:0]};
                        chk(e == 2'd0, "R7 error code", e, 0);
                        chk(d == dfn(exp_conf, exp_mode), "R7 result data", d, dfn(exp_conf, exp_mode));
                        chk(cs_rises - cr == 1, "R10 chip select held", cs_rises - cr, 1);
                    end
                end
                // rejected rates
                for (int ri = 0; ri < 3; ri++) begin
                    logic [11:0] r;
                    r = (ri == 0) ? 12'd0 : (ri == 1) ? 12'd1024 : 12'd4095;
                    fb = sclk_falls;
                    do_req(3'd2, r, d, e, lat);
                    chk(e == 2'd1 && d == 24'h0, "R8 rate rejected", {e, d}, {2'd1, 24'h0});
                    chk(sclk_falls == fb, "R8 no serial clocks", sclk_falls - fb, 0);
                    chk(lat <= 1, "R8 immediate answer", lat, 1);
                end
                // timeout
                no_ready = 1'b1;
                do_req(3'd5, 12'd77, d, e, lat);
                chk(e == 2'd2, "R9 timeout code", e, 2);
                chk(lat >= TIMEOUT, "R9 timeout latency", lat, TIMEOUT);
                no_ready = 1'b0;
                repeat (CONV_CLKS + 50) @(negedge clk);
                do_req(3'd3, 12'd200, d, e, lat);
                exp_conf = (CONF_BASE & ~24'h07FF00) | (24'h1 << 11);
                exp_mode = {3'd1, 1'b0, CLK_SRC, 8'h00, 10'd200};
                chk(e == 2'd0 && d == dfn(exp_conf, exp_mode), "R9 recovery after timeout",
                    {e, d}, {2'd0, dfn(exp_conf, exp_mode)});
                chk(viol == 0, "R4 R6 command format and ready ordering", viol, 0);
                // second bring-up with wrong identity
                model_id = 8'hB7;
                init_run();
                chk(id_warn, "R3 id mismatch warns", id_warn, 1);
                chk(req_ready, "R3 continues after mismatch", req_ready, 1);
            end
            begin
                repeat (190000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule